// File: doc/BRIEF.md
# Core Memory Replacement Cycle Controller

This block lets a static memory with asynchronous control pins stand in for the magnetic core storage of a legacy CPU. The CPU presents level signals that mark a storage cycle in use, its read phase and its write phase, together with a power-good level, a 13-bit word address and 16 active-low write-data bits. The controller turns these into the memory's active-low chip enable, write enable and output enable, and into the enable of the external write-data buffer. Write enable is a short timed pulse opened when the write phase begins.

On a read, the CPU does not expect levels back. It expects a falling-edge pulse on a sense line for every stored 1 bit, and it checks odd parity per 8-bit halfword. Some fixed time after the read phase begins, the controller captures the memory word and opens a read window. For that whole window it pulls low the sense line of each 1 bit and, for each halfword, a parity line, so that the count of pulses in that halfword is odd. The read and write levels are synchronized to a fast system clock. Every delay and width is a cycle count set by a parameter. If the cycle is dropped or power fails, all timing is cancelled at once.

Top module: `core_cycle_ctrl`

## Requirements
- R1: `mem_ce_n` is low exactly while `pwr_good` and `stor_use` are both high.
- R2: After `stor_write` rises, `mem_we_n` goes low at the third rising clock edge and stays low for WR_WIDTH clock cycles. It is low only while the cycle is active and the synchronized write level is high.
- R3: `mem_oe_n` is low while the cycle is active and the synchronized write level (delayed two clock edges) is low.
- R4: `wbuf_en_n` is low while the cycle is active and the synchronized write level is high. `wbuf_en_n` and `mem_oe_n` are never low together.
- R5: After `stor_read` rises, the read window opens at the third rising edge plus RD_DELAY further edges and lasts RD_WIDTH cycles. The memory word is captured at the edge that opens the window.
- R6: During the read window, `sense_n[i]` is low if and only if bit i of the captured word is 1. Outside the window every sense line stays high.
- R7: `par_n[0]` covers data bits 7:0 and `par_n[1]` covers bits 15:8. During the read window a parity line is low if and only if its halfword holds an even number of 1 bits. So an all-zero halfword pulses and a halfword with exactly one 1 bit stays idle high.
- R8: `mem_addr` always equals `addr_in`, and `mem_wdata` is the bitwise inverse of `wdata_n`.
- R9: When `pwr_good` or `stor_use` drops, every control, sense and parity output goes inactive (high) at once. Any pending read or write timing is cancelled and does not resume while the read or write level stays high.
- R10: After reset, with the cycle inactive, all active-low outputs are high.
- R11: A rising edge on the read or write level that arrives while its timer is still running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply good level |
| stor_use | input | 1 | Storage cycle in use |
| stor_read | input | 1 | Read phase level (asynchronous) |
| stor_write | input | 1 | Write phase level (asynchronous) |
| addr_in | input | 13 | Word address from the CPU |
| wdata_n | input | 16 | Active-low write data from the CPU |
| mem_rdata | input | 16 | Data read from the memory |
| mem_addr | output | 13 | Address to the memory |
| mem_wdata | output | 16 | True-polarity write data toward the buffer |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| wbuf_en_n | output | 1 | Write-data buffer enable, active low |
| sense_n | output | 16 | Per-bit sense pulses, active low |
| par_n | output | 2 | Per-halfword parity pulses, active low |

## Verification
The assertions assume a few things about the inputs. The CPU holds `pwr_good` and `stor_use` as levels around a whole cycle. The memory data is steady at the edge that opens the read window. Read and write phases do not rise in the same cycle. The stimulus wraps each read or write inside a raised `stor_use`. It holds each phase level for longer than its timer runs, and it lowers one phase before raising the other. Abort cases are the only place where `stor_use` or `pwr_good` falls while a phase level is still high.

// File: rtl/cc_pkg.sv
package cc_pkg;
   typedef enum logic [1:0] {
      TM_IDLE  = 2'd0,
      TM_WAIT  = 2'd1,
      TM_PULSE = 2'd2
   } tmr_state_e;
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   logic [STAGES-1:0] sh;
   logic              q_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cc_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         q_prev <= 1'b0;
      end else begin
         sh     <= {sh[STAGES-2:0], d};
         q_prev <= sh[STAGES-1];
      end
   end

   assign q    = sh[STAGES-1];
   assign rise = sh[STAGES-1] & ~q_prev;
endmodule

// File: rtl/cc_pulse_timer.sv
module cc_pulse_timer
   import cc_pkg::*;
#(
   parameter int DELAY = 3,
   parameter int WIDTH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic start,
   output logic go,
   output logic pulse
);
   localparam int CNT_MAX = (DELAY > WIDTH) ? DELAY : WIDTH;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] LD_W   = CW'(WIDTH - 1);
   localparam logic [CW-1:0] LD_DLY = (DELAY > 0) ? CW'(DELAY - 1) : '0;

   tmr_state_e    st;
   logic [CW-1:0] cnt;
   logic          direct_go;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("cc_pulse_timer: WIDTH must be at least 1");
      end
      if (DELAY == 0) begin : g_no_delay
         assign direct_go = (st == TM_IDLE) & start;
      end else begin : g_delay
         assign direct_go = 1'b0;
      end
   endgenerate

   assign go    = ~abort & (direct_go | ((st == TM_WAIT) & (cnt == '0)));
   assign pulse = (st == TM_PULSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= TM_IDLE;
         cnt <= '0;
      end else if (abort) begin
         st  <= TM_IDLE;
         cnt <= '0;
      end else if (go) begin
         st  <= TM_PULSE;
         cnt <= LD_W;
      end else begin
         case (st)
            TM_IDLE: begin
               if (start) begin
                  st  <= TM_WAIT;
                  cnt <= LD_DLY;
               end
            end
            TM_WAIT: cnt <= cnt - 1'b1;
            TM_PULSE: begin
               if (cnt == '0) st <= TM_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= TM_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cc_parity_gen.sv
module cc_parity_gen #(
   parameter int DATA_W = 16,
   parameter int HALF_W = 8
) (
   input  logic [DATA_W-1:0]        data,
   input  logic                     en,
   output logic [DATA_W/HALF_W-1:0] par_n
);
   localparam int NH = DATA_W / HALF_W;

   generate
      if (DATA_W % HALF_W != 0) begin : g_bad_split
         $error("cc_parity_gen: DATA_W must be a multiple of HALF_W");
      end
      for (genvar h = 0; h < NH; h++) begin : g_half
         assign par_n[h] = ~(en & ~(^data[h*HALF_W +: HALF_W]));
      end
   endgenerate
endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl #(
   parameter int ADDR_W      = 13,
   parameter int DATA_W      = 16,
   parameter int HALF_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RD_DELAY    = 3,
   parameter int RD_WIDTH    = 5,
   parameter int WR_WIDTH    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pwr_good,
   input  logic                     stor_use,
   input  logic                     stor_read,
   input  logic                     stor_write,
   input  logic [ADDR_W-1:0]        addr_in,
   input  logic [DATA_W-1:0]        wdata_n,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [DATA_W-1:0]        mem_wdata,
   output logic                     mem_ce_n,
   output logic                     mem_we_n,
   output logic                     mem_oe_n,
   output logic                     wbuf_en_n,
   output logic [DATA_W-1:0]        sense_n,
   output logic [DATA_W/HALF_W-1:0] par_n
);
   localparam int NH = DATA_W / HALF_W;

   generate
      if (RD_DELAY < 1) begin : g_bad_rd_delay
         $error("core_cycle_ctrl: RD_DELAY must be at least 1");
      end
      if (NH < 1) begin : g_bad_halves
         $error("core_cycle_ctrl: HALF_W must not exceed DATA_W");
      end
   endgenerate

   logic              act;
   logic              rd_s, rd_rise, wr_s, wr_rise;
   logic              rd_go, rd_pulse, wr_go, wr_pulse;
   logic [DATA_W-1:0] data_q;
   logic              show;

   assign act = pwr_good & stor_use;

   cc_sync_edge #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .d(stor_read), .q(rd_s), .rise(rd_rise));

   cc_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .d(stor_write), .q(wr_s), .rise(wr_rise));

   cc_pulse_timer #(.DELAY(RD_DELAY), .WIDTH(RD_WIDTH)) u_rd_tmr (
      .clk(clk), .rst_n(rst_n), .abort(~act), .start(rd_rise),
      .go(rd_go), .pulse(rd_pulse));

   cc_pulse_timer #(.DELAY(0), .WIDTH(WR_WIDTH)) u_wr_tmr (
      .clk(clk), .rst_n(rst_n), .abort(~act), .start(wr_rise),
      .go(wr_go), .pulse(wr_pulse));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data_q <= '0;
      else if (rd_go) data_q <= mem_rdata;
   end

   assign show = rd_pulse & act;

   cc_parity_gen #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_par (
      .data(data_q), .en(show), .par_n(par_n));

   assign sense_n   = ~(data_q & {DATA_W{show}});
   assign mem_ce_n  = ~act;
   assign mem_oe_n  = ~(act & ~wr_s);
   assign wbuf_en_n = ~(act & wr_s);
   assign mem_we_n  = ~(act & wr_s & wr_pulse);
   assign mem_addr  = addr_in;
   assign mem_wdata = ~wdata_n;

   logic unused_wr_go;
   assign unused_wr_go = wr_go;
endmodule

// File: rtl/cc_cycle_checker.sv
module cc_cycle_checker #(
   parameter int DATA_W = 16,
   parameter int HALF_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     pwr_good,
   input logic                     stor_use,
   input logic                     mem_ce_n,
   input logic                     mem_we_n,
   input logic                     mem_oe_n,
   input logic                     wbuf_en_n,
   input logic [DATA_W-1:0]        sense_n,
   input logic [DATA_W/HALF_W-1:0] par_n,
   input logic                     rd_pulse,
   input logic                     wr_pulse
);
   localparam int NH = DATA_W / HALF_W;

   // R4: buffer drive and memory output never overlap
   a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !wbuf_en_n));

   // R2: a write strobe never appears outside a selected chip, nor with output on
   a_r2_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && wr_pulse));

   // R9: losing the cycle cancels both timers by the next edge
   a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_good && stor_use) |=> (!rd_pulse && !wr_pulse));

   // R6: sense lines hold steady across an uninterrupted read window
   a_r6_sense_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pulse && $past(rd_pulse) && pwr_good && stor_use && $past(pwr_good && stor_use))
      |-> $stable(sense_n));

   // R6: no sense pulse outside the read window
   a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_pulse |-> (&sense_n && &par_n));

   generate
      for (genvar h = 0; h < NH; h++) begin : g_par_chk
         // R7: each halfword plus its parity line carries an odd pulse count
         a_r7_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_pulse && pwr_good && stor_use) |->
            ((^{~sense_n[h*HALF_W +: HALF_W], ~par_n[h]}) == 1'b1));
      end
   endgenerate
endmodule

bind core_cycle_ctrl cc_cycle_checker #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .stor_use(stor_use),
   .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
   .wbuf_en_n(wbuf_en_n), .sense_n(sense_n), .par_n(par_n),
   .rd_pulse(rd_pulse), .wr_pulse(wr_pulse));

// File: tb/core_cycle_ctrl_tb.sv
module core_cycle_ctrl_tb;
   localparam int RDD = 3;
   localparam int RDW = 5;
   localparam int WRW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_good = 1'b0, stor_use = 1'b0, stor_read = 1'b0, stor_write = 1'b0;
   logic [12:0] addr_in = '0;
   logic [15:0] wdata_n = 16'hFFFF;
   logic [15:0] mem_rdata;
   logic [12:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_ce_n, mem_we_n, mem_oe_n, wbuf_en_n;
   logic [15:0] sense_n;
   logic [1:0]  par_n;

   core_cycle_ctrl #(.RD_DELAY(RDD), .RD_WIDTH(RDW), .WR_WIDTH(WRW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .stor_use(stor_use),
      .stor_read(stor_read), .stor_write(stor_write), .addr_in(addr_in),
      .wdata_n(wdata_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .wbuf_en_n(wbuf_en_n), .sense_n(sense_n), .par_n(par_n));

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit running = 1'b0;

   // behavioural memory, 64 words
   logic [15:0] mem_m [0:63];
   assign mem_rdata = (!mem_ce_n && !mem_oe_n) ? mem_m[mem_addr[5:0]] : 16'hFFFF;

   // reference model state
   logic [1:0]  rsh = '0, wsh = '0;
   logic        rprev = 1'b0, wprev = 1'b0;
   int          rcount = 0, wcount = 0;
   logic [15:0] mdata = '0;

   // directed pulse counters
   int sl_cnt [16];
   int pl_cnt [2];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         rsh <= '0; wsh <= '0; rprev <= 1'b0; wprev <= 1'b0;
         rcount <= 0; wcount <= 0; mdata <= '0;
      end else begin
         if (!mem_ce_n && !mem_we_n) mem_m[mem_addr[5:0]] <= mem_wdata;
         rsh <= {rsh[0], stor_read};
         wsh <= {wsh[0], stor_write};
         rprev <= rsh[1];
         wprev <= wsh[1];
         if (!(pwr_good && stor_use)) begin
            rcount <= 0;
            wcount <= 0;
         end else begin
            if (rcount == 0) begin
               if (rsh[1] && !rprev) rcount <= 1;
            end else if (rcount == RDD + RDW) rcount <= 0;
            else begin
               rcount <= rcount + 1;
               if (rcount == RDD) mdata <= mem_rdata;
            end
            if (wcount == 0) begin
               if (wsh[1] && !wprev) wcount <= 1;
            end else if (wcount == WRW) wcount <= 0;
            else wcount <= wcount + 1;
         end
      end
   end

   // compare against the model away from the clock edge
   always @(posedge clk) begin
      #5;
      if (running) begin
         logic        a, win;
         logic [15:0] es;
         logic [1:0]  ep;
         a   = pwr_good & stor_use;
         win = a && (rcount > RDD);
         es  = win ? ~mdata : 16'hFFFF;
         ep[0] = ~(win && ((($countones(mdata[7:0])) % 2) == 0));
         ep[1] = ~(win && ((($countones(mdata[15:8])) % 2) == 0));
         check(mem_ce_n == ~a, "R1 ce_n", {31'd0, mem_ce_n}, {31'd0, ~a});
         check(mem_we_n == ~(a && wsh[1] && wcount > 0), "R2 we_n", {31'd0, mem_we_n}, {31'd0, ~(a && wsh[1] && wcount > 0)});
         check(mem_oe_n == ~(a && !wsh[1]), "R3 oe_n", {31'd0, mem_oe_n}, {31'd0, ~(a && !wsh[1])});
         check(wbuf_en_n == ~(a && wsh[1]), "R4 wbuf_en_n", {31'd0, wbuf_en_n}, {31'd0, ~(a && wsh[1])});
         check(sense_n == es, "R6 sense_n", {16'd0, sense_n}, {16'd0, es});
         check(par_n == ep, "R7 par_n", {30'd0, par_n}, {30'd0, ep});
         check(mem_addr == addr_in && mem_wdata == ~wdata_n, "R8 passthrough",
               {3'd0, mem_addr, mem_wdata}, {3'd0, addr_in, ~wdata_n});
         if (!a) check(&{mem_we_n, mem_oe_n, wbuf_en_n, sense_n, par_n}, "R9 abort outputs",
                       {11'd0, mem_we_n, mem_oe_n, wbuf_en_n, sense_n, par_n}, 32'h001F_FFFF);
         for (int i = 0; i < 16; i++) if (!sense_n[i]) sl_cnt[i]++;
         for (int h = 0; h < 2; h++) if (!par_n[h]) pl_cnt[h]++;
      end
   end

   task automatic clr_cnt();
      for (int i = 0; i < 16; i++) sl_cnt[i] = 0;
      for (int h = 0; h < 2; h++) pl_cnt[h] = 0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input logic [12:0] a, input logic [15:0] d);
      @(negedge clk);
      addr_in = a; wdata_n = ~d; stor_use = 1'b1;
      cyc(1); stor_write = 1'b1;
      cyc(WRW + 6); stor_write = 1'b0;
      cyc(3); stor_use = 1'b0;
      cyc(2);
   endtask

   task automatic do_read(input logic [12:0] a, input logic [15:0] d, input string tag);
      int ones;
      @(negedge clk);
      clr_cnt();
      addr_in = a; stor_use = 1'b1;
      cyc(1); stor_read = 1'b1;
      cyc(RDD + RDW + 6); stor_read = 1'b0;
      cyc(2); stor_use = 1'b0;
      cyc(2);
      // R5 R6: each 1 bit pulses for exactly the window, each 0 bit stays idle
      for (int i = 0; i < 16; i++)
         check(sl_cnt[i] == (d[i] ? RDW : 0), {tag, " R5 R6 sense count"}, sl_cnt[i], d[i] ? RDW : 0);
      // R7: parity pulses only for an even halfword
      for (int h = 0; h < 2; h++) begin
         ones = $countones(d[h*8 +: 8]);
         check(pl_cnt[h] == ((ones % 2 == 0) ? RDW : 0), {tag, " R7 parity count"}, pl_cnt[h],
               (ones % 2 == 0) ? RDW : 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem_m[i] = '0;
      clr_cnt();
      repeat (3) @(negedge clk);
      // R10: reset state with the cycle inactive
      check(&{mem_ce_n, mem_we_n, mem_oe_n, wbuf_en_n, sense_n, par_n}, "R10 reset outputs",
            {10'd0, mem_ce_n, mem_we_n, mem_oe_n, wbuf_en_n, sense_n, par_n}, 32'h003F_FFFF);
      rst_n = 1'b1;
      pwr_good = 1'b1;
      running = 1'b1;
      cyc(2);

      do_write(13'd1, 16'h0000); do_read(13'd1, 16'h0000, "zero");
      do_write(13'd2, 16'h0001); do_read(13'd2, 16'h0001, "one_low");
      do_write(13'd3, 16'h8000); do_read(13'd3, 16'h8000, "one_high");
      do_write(13'd4, 16'hFFFF); do_read(13'd4, 16'hFFFF, "all_ones");
      do_write(13'd5, 16'h0307); do_read(13'd5, 16'h0307, "mixed");
      do_write(13'd6, 16'hA5C3); do_read(13'd6, 16'hA5C3, "pattern");

      // R9: drop stor_use while the read waits; window must never open
      @(negedge clk);
      clr_cnt();
      addr_in = 13'd4; stor_use = 1'b1;
      cyc(1); stor_read = 1'b1;
      cyc(3); stor_use = 1'b0;
      cyc(2); stor_use = 1'b1;
      cyc(RDD + RDW + 4);
      check(sl_cnt[0] == 0 && pl_cnt[0] == 0, "R9 aborted read", sl_cnt[0], 0);
      stor_read = 1'b0; cyc(2); stor_use = 1'b0; cyc(2);

      // R9: power loss mid write leaves the old word in memory
      @(negedge clk);
      addr_in = 13'd6; wdata_n = ~16'h1234; stor_use = 1'b1;
      cyc(1); stor_write = 1'b1;
      cyc(2); pwr_good = 1'b0;
      cyc(WRW + 4); stor_write = 1'b0; pwr_good = 1'b1;
      cyc(2); stor_use = 1'b0; cyc(2);
      do_read(13'd6, 16'hA5C3, "after_pwr_loss");

      // R11: a read edge re-raised during the window is ignored
      @(negedge clk);
      clr_cnt();
      addr_in = 13'd4; stor_use = 1'b1;
      cyc(1); stor_read = 1'b1;
      cyc(RDD + 3); stor_read = 1'b0;
      cyc(1); stor_read = 1'b1;
      cyc(4); stor_read = 1'b0;
      cyc(RDD + RDW + 4); stor_use = 1'b0; cyc(2);
      check(sl_cnt[3] == RDW, "R11 retrigger ignored", sl_cnt[3], RDW);

      running = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule